// File: doc/BRIEF.md
# PRBS Channel Tester

This block drives a pseudo-random bit sequence into one timeslot channel of one time-division-multiplexed serial link and checks the same channel on the way back. A slot strobe arrives from the link multiplexer together with the link and channel number of the slot that is current. When the strobe matches the configured route and the tester is enabled, the block returns the byte to transmit in that same cycle and takes the byte received in that slot. The transmitted byte is either the next eight bits of a PRBS15 sequence (x^15 + x^14 + 1) or a fixed fill byte, depending on the selected mode.

The checker keeps a local reference register. It loads this register from the incoming bits until a run of correct predictions shows that it is in step with the far-end sequence, and it then runs free and counts mismatches. Error and bit counters are read over a Wishbone slave port, and software divides one by the other to get the error rate. Writing a clear bit zeroes both counters and forces the checker to resynchronise.

The slot strobe acts as the valid signal of both byte streams. The block never applies back-pressure: every selected strobe is accepted in the cycle it is presented, so the multiplexer needs no ready input.

Top module: `prbs_chan_tester`

## Requirements
- R1: The generator is a 15-bit shift register with feedback state[14] XOR state[13]. It is seeded with all ones at reset and never holds all zeros. Each byte takes eight successive feedback bits, with the first bit placed in bit 7 and each new bit shifted in at bit 0.
- R2: tx_sel_o is high exactly when frm_stb_i is high, frm_link_i equals ROUTE[7:0], frm_chan_i equals ROUTE[15:8], and CTRL bit 0 (enable) is set. tx_byte_o is zero whenever tx_sel_o is low. In PRBS mode the generator advances by one byte for each selected slot.
- R3: When CTRL bit 1 is set (static mode), every selected slot carries FILL[7:0] and the generator does not advance. When PRBS mode is restored, the sequence continues from where it stopped.
- R4: In PRBS mode the checker declares lock (STATUS bit 0) once 32 consecutive received bits match its prediction. While unlocked, each received bit is shifted into the reference. No lock can be declared after fewer than 32 bits.
- R5: While locked in PRBS mode, each received bit adds one to BITS and each bit that differs from the free-running reference adds one to ERRS. Bits received before lock are not counted.
- R6: In static mode each selected slot adds 8 to BITS and adds to ERRS the number of bits in which the received byte differs from FILL. Lock is not needed for this.
- R7: While enable is clear, received bytes are ignored, the counters hold their values, and lock is dropped.
- R8: ERRS and BITS saturate at all ones and do not wrap.
- R9: Writing CTRL with bit 2 set zeroes ERRS and BITS, clears lock and the lock run, and empties the reference. Bit 2 reads back as 0. If the clear is accepted in the same cycle as a selected slot, the clear wins and that slot's byte is not counted.
- R10: The register map uses word addresses on wb_adr_i: 0 CTRL, 1 ROUTE, 2 FILL, 3 STATUS, 4 ERRS, 5 BITS. A cycle is accepted when cyc and stb are high and ack is low. Ack is a one-cycle pulse in the following cycle, and it carries read data taken at the accepting edge. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | 3 | Register word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Cycle acknowledge |
| frm_stb_i | input | 1 | Slot strobe, the valid for rx_byte_i and tx_byte_o |
| frm_link_i | input | $clog2(LINKS) | Link number of the current slot |
| frm_chan_i | input | $clog2(CHANS) | Channel number of the current slot |
| rx_byte_i | input | 8 | Byte received in the current slot |
| tx_sel_o | output | 1 | Current slot is the tester's slot |
| tx_byte_o | output | 8 | Byte to transmit in the current slot |

## Verification
A clear written over the bus and a selected slot can reach the same clock edge. In that case both want to update the checker and the counters. The bench drives a CTRL write carrying the clear bit and a matching slot strobe on the same edge, with a received byte that differs from the fill in every bit. It then reads both counters and expects zero, because the slot must be dropped. One more slot then has to show exactly eight errors and eight bits. Around this case the bench runs random PRBS streams with bit flips and random static bytes, and it compares both counters and the lock state with a bit-level model of the checker.

// File: rtl/prbs_pkg.sv
`timescale 1ns/1ps
package prbs_pkg;

  typedef enum logic {
    FILL_PRBS   = 1'b0,
    FILL_STATIC = 1'b1
  } fill_mode_e;

  // Register word addresses
  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_ROUTE = 3'd1;
  localparam logic [2:0] ADR_FILL  = 3'd2;
  localparam logic [2:0] ADR_STAT  = 3'd3;
  localparam logic [2:0] ADR_ERRS  = 3'd4;
  localparam logic [2:0] ADR_BITS  = 3'd5;

  // Control bit positions
  localparam int CTRL_EN     = 0;
  localparam int CTRL_STATIC = 1;
  localparam int CTRL_CLR    = 2;

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/prbs_gen.sv
`timescale 1ns/1ps
module prbs_gen #(
  parameter int unsigned LEN = 15,
  parameter int unsigned TAP = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv_i,
  output logic [7:0]     byte_o,
  output logic [LEN-1:0] state_o
);

  logic [LEN-1:0] st_q;
  logic [LEN-1:0] st_nxt;
  logic [7:0]     byte_nxt;

  // Look eight feedback steps ahead of the current state
  always_comb begin
    logic [LEN-1:0] t;
    logic           fb;
    t = st_q;
    byte_nxt = '0;
    for (int i = 7; i >= 0; i--) begin
      fb = t[LEN-1] ^ t[TAP-1];
      byte_nxt[i] = fb;
      t = {t[LEN-2:0], fb};
    end
    st_nxt = t;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '1;
    else if (adv_i) st_q <= st_nxt;
  end

  assign byte_o  = byte_nxt;
  assign state_o = st_q;

endmodule

// File: rtl/prbs_chk.sv
`timescale 1ns/1ps
module prbs_chk
  import prbs_pkg::*;
#(
  parameter int unsigned LEN      = 15,
  parameter int unsigned TAP      = 14,
  parameter int unsigned LOCK_RUN = 32,
  parameter int unsigned CNT_W    = 32,
  localparam int unsigned GW      = $clog2(LOCK_RUN + 1),
  localparam int unsigned SW      = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  fill_mode_e       mode_i,
  input  logic [7:0]       fill_i,
  input  logic             take_i,
  input  logic [7:0]       rx_i,
  output logic             lock_o,
  output logic [CNT_W-1:0] err_o,
  output logic [CNT_W-1:0] bits_o
);

  localparam logic [GW-1:0] RUN_G = GW'(LOCK_RUN);

  logic [LEN-1:0]   ref_q, ref_d;
  logic [GW-1:0]    good_q, good_d;
  logic             lock_q, lock_d;
  logic [CNT_W-1:0] err_q, bits_q;
  logic [3:0]       e_add, b_add;

  // Byte-parallel walk through eight received bits, MSB first
  always_comb begin
    logic p;
    ref_d  = ref_q;
    good_d = good_q;
    lock_d = lock_q;
    e_add  = '0;
    b_add  = '0;
    p      = 1'b0;
    if (mode_i == FILL_STATIC) begin
      e_add = ones8(rx_i ^ fill_i);
      b_add = 4'd8;
    end else begin
      for (int i = 7; i >= 0; i--) begin
        p = ref_d[LEN-1] ^ ref_d[TAP-1];
        if (lock_d) begin
          b_add = b_add + 4'd1;
          if (rx_i[i] != p) e_add = e_add + 4'd1;
          ref_d = {ref_d[LEN-2:0], p};
        end else begin
          if (rx_i[i] == p) begin
            if (good_d != RUN_G) good_d = good_d + 1'b1;
          end else begin
            good_d = '0;
          end
          ref_d = {ref_d[LEN-2:0], rx_i[i]};
          if (good_d == RUN_G) lock_d = 1'b1;
        end
      end
    end
  end

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [3:0] b);
    logic [SW-1:0] s;
    s = {1'b0, a} + SW'(b);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      ref_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
      err_q  <= '0;
      bits_q <= '0;
    end else if (!run_i) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (take_i) begin
      ref_q  <= ref_d;
      good_q <= good_d;
      lock_q <= lock_d;
      err_q  <= sat_add(err_q, e_add);
      bits_q <= sat_add(bits_q, b_add);
    end
  end

  assign lock_o = lock_q;
  assign err_o  = err_q;
  assign bits_o = bits_q;

endmodule

// File: rtl/prbs_wb_regs.sv
`timescale 1ns/1ps
module prbs_wb_regs
  import prbs_pkg::*;
#(
  parameter int unsigned LW    = 3,
  parameter int unsigned CW    = 5,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [2:0]       adr_i,
  input  logic [31:0]      dat_i,
  output logic [31:0]      dat_o,
  output logic             ack_o,
  input  logic             lock_i,
  input  logic [CNT_W-1:0] err_i,
  input  logic [CNT_W-1:0] bits_i,
  output logic             en_o,
  output fill_mode_e       mode_o,
  output logic [LW-1:0]    link_o,
  output logic [CW-1:0]    chan_o,
  output logic [7:0]       fill_o,
  output logic             clr_o
);

  logic          ack_q;
  logic [31:0]   dat_q, rd;
  logic          en_q;
  fill_mode_e    mode_q;
  logic [LW-1:0] link_q;
  logic [CW-1:0] chan_q;
  logic [7:0]    fill_q;
  logic          accept, wr;

  assign accept = cyc_i && stb_i && !ack_q;
  assign wr     = accept && we_i;
  assign clr_o  = wr && (adr_i == ADR_CTRL) && dat_i[CTRL_CLR];

  always_comb begin
    rd = '0;
    case (adr_i)
      ADR_CTRL: begin
        rd[CTRL_EN]     = en_q;
        rd[CTRL_STATIC] = (mode_q == FILL_STATIC);
      end
      ADR_ROUTE: begin
        rd[LW-1:0] = link_q;
        rd[8 +: CW] = chan_q;
      end
      ADR_FILL:  rd[7:0] = fill_q;
      ADR_STAT:  rd[0] = lock_i;
      ADR_ERRS:  rd = 32'(err_i);
      ADR_BITS:  rd = 32'(bits_i);
      default:   rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      dat_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= FILL_PRBS;
      link_q <= '0;
      chan_q <= '0;
      fill_q <= '0;
    end else begin
      ack_q <= accept;
      if (accept && !we_i) dat_q <= rd;
      if (wr) begin
        case (adr_i)
          ADR_CTRL: begin
            en_q   <= dat_i[CTRL_EN];
            mode_q <= dat_i[CTRL_STATIC] ? FILL_STATIC : FILL_PRBS;
          end
          ADR_ROUTE: begin
            link_q <= dat_i[LW-1:0];
            chan_q <= dat_i[8 +: CW];
          end
          ADR_FILL: fill_q <= dat_i[7:0];
          default: ;
        endcase
      end
    end
  end

  assign ack_o  = ack_q;
  assign dat_o  = dat_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign link_o = link_q;
  assign chan_o = chan_q;
  assign fill_o = fill_q;

endmodule

// File: rtl/prbs_chan_tester.sv
`timescale 1ns/1ps
module prbs_chan_tester
  import prbs_pkg::*;
#(
  parameter int unsigned LINKS    = 8,
  parameter int unsigned CHANS    = 32,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned PRBS_LEN = 15,
  parameter int unsigned PRBS_TAP = 14,
  parameter int unsigned LOCK_RUN = 32,
  localparam int unsigned LW      = $clog2(LINKS),
  localparam int unsigned CW      = $clog2(CHANS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_cyc_i,
  input  logic          wb_stb_i,
  input  logic          wb_we_i,
  input  logic [2:0]    wb_adr_i,
  input  logic [31:0]   wb_dat_i,
  output logic [31:0]   wb_dat_o,
  output logic          wb_ack_o,
  input  logic          frm_stb_i,
  input  logic [LW-1:0] frm_link_i,
  input  logic [CW-1:0] frm_chan_i,
  input  logic [7:0]    rx_byte_i,
  output logic          tx_sel_o,
  output logic [7:0]    tx_byte_o
);

  logic                cfg_en;
  fill_mode_e          cfg_mode;
  logic [LW-1:0]       cfg_link;
  logic [CW-1:0]       cfg_chan;
  logic [7:0]          cfg_fill;
  logic                clr_pulse;
  logic                chk_lock;
  logic [CNT_W-1:0]    err_cnt, bit_cnt;
  logic [7:0]          gen_byte;
  logic [PRBS_LEN-1:0] gen_state;
  logic                slot_hit;

  prbs_wb_regs #(.LW(LW), .CW(CW), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i),
    .adr_i(wb_adr_i), .dat_i(wb_dat_i), .dat_o(wb_dat_o), .ack_o(wb_ack_o),
    .lock_i(chk_lock), .err_i(err_cnt), .bits_i(bit_cnt),
    .en_o(cfg_en), .mode_o(cfg_mode), .link_o(cfg_link), .chan_o(cfg_chan),
    .fill_o(cfg_fill), .clr_o(clr_pulse)
  );

  assign slot_hit = frm_stb_i && cfg_en &&
                    (frm_link_i == cfg_link) && (frm_chan_i == cfg_chan);

  prbs_gen #(.LEN(PRBS_LEN), .TAP(PRBS_TAP)) gen_i (
    .clk(clk), .rst_n(rst_n),
    .adv_i(slot_hit && (cfg_mode == FILL_PRBS)),
    .byte_o(gen_byte), .state_o(gen_state)
  );

  prbs_chk #(.LEN(PRBS_LEN), .TAP(PRBS_TAP), .LOCK_RUN(LOCK_RUN), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_pulse), .run_i(cfg_en),
    .mode_i(cfg_mode), .fill_i(cfg_fill), .take_i(slot_hit), .rx_i(rx_byte_i),
    .lock_o(chk_lock), .err_o(err_cnt), .bits_o(bit_cnt)
  );

  assign tx_sel_o  = slot_hit;
  assign tx_byte_o = !slot_hit ? 8'h00 :
                     (cfg_mode == FILL_STATIC) ? cfg_fill : gen_byte;

endmodule

// File: rtl/prbs_chan_tester_sva.sv
`timescale 1ns/1ps
module prbs_chan_tester_sva #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned PRBS_LEN = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wb_ack_o,
  input logic                frm_stb_i,
  input logic                tx_sel_o,
  input logic                cfg_en,
  input logic                clr_pulse,
  input logic                chk_lock,
  input logic [CNT_W-1:0]    err_cnt,
  input logic [CNT_W-1:0]    bit_cnt,
  input logic [PRBS_LEN-1:0] gen_state
);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o); // R10
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_state != '0); // R1
  AST_TX_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sel_o |-> frm_stb_i); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !clr_pulse) |=> ($stable(err_cnt) && $stable(bit_cnt) && !chk_lock)); // R7
  AST_ERR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= bit_cnt); // R5
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (err_cnt == '0 && bit_cnt == '0 && !chk_lock)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((&bit_cnt) && !clr_pulse) |=> (&bit_cnt)); // R8

endmodule

bind prbs_chan_tester prbs_chan_tester_sva #(.CNT_W(CNT_W), .PRBS_LEN(PRBS_LEN)) sva_i (
  .clk(clk), .rst_n(rst_n), .wb_ack_o(wb_ack_o), .frm_stb_i(frm_stb_i),
  .tx_sel_o(tx_sel_o), .cfg_en(cfg_en), .clr_pulse(clr_pulse),
  .chk_lock(chk_lock), .err_cnt(err_cnt), .bit_cnt(bit_cnt), .gen_state(gen_state)
);

// File: tb/prbs_chan_tester_tb_top.sv
`timescale 1ns/1ps
module prbs_chan_tester_tb_top;

  localparam int CNT_W = 10;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int LINK  = 5;
  localparam int CHAN  = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [2:0]  wb_adr = '0;
  logic [31:0] wb_dat_w = '0;
  logic [31:0] wb_dat_r;
  logic        wb_ack;
  logic        frm_stb = 0;
  logic [2:0]  frm_link = '0;
  logic [4:0]  frm_chan = '0;
  logic [7:0]  rx_byte = '0;
  logic        tx_sel;
  logic [7:0]  tx_byte;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  prbs_chan_tester #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we), .wb_adr_i(wb_adr),
    .wb_dat_i(wb_dat_w), .wb_dat_o(wb_dat_r), .wb_ack_o(wb_ack),
    .frm_stb_i(frm_stb), .frm_link_i(frm_link), .frm_chan_i(frm_chan),
    .rx_byte_i(rx_byte), .tx_sel_o(tx_sel), .tx_byte_o(tx_byte)
  );

  // ---------------- reference models ----------------
  logic [14:0] g_st;                 // generator model
  logic [14:0] m_ref;                // checker model
  int          m_good, m_err, m_bits;
  bit          m_lock, m_en, m_static;
  logic [7:0]  m_fill;

  function automatic logic [7:0] prbs_byte(input logic [14:0] s);
    logic [7:0] b;
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = s[14] ^ s[13];
      b[i] = fb;
      s = {s[13:0], fb};
    end
    return b;
  endfunction

  function automatic logic [14:0] prbs_next(input logic [14:0] s);
    for (int i = 0; i < 8; i++) s = {s[13:0], s[14] ^ s[13]};
    return s;
  endfunction

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic model_clear();
    m_ref = '0; m_good = 0; m_lock = 0; m_err = 0; m_bits = 0;
  endtask

  task automatic model_rx(input logic [7:0] rx);
    logic p;
    int e, b;
    e = 0; b = 0;
    if (m_static) begin
      for (int i = 0; i < 8; i++) e += int'(rx[i] ^ m_fill[i]);
      b = 8;
    end else begin
      for (int i = 7; i >= 0; i--) begin
        p = m_ref[14] ^ m_ref[13];
        if (m_lock) begin
          b++;
          if (rx[i] != p) e++;
          m_ref = {m_ref[13:0], p};
        end else begin
          if (rx[i] == p) begin if (m_good < 32) m_good++; end
          else m_good = 0;
          m_ref = {m_ref[13:0], rx[i]};
          if (m_good == 32) m_lock = 1;
        end
      end
    end
    m_err  = sat(m_err + e);
    m_bits = sat(m_bits + b);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- bus and slot tasks ----------------
  task automatic wb_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = a; wb_dat_w = d;
    @(posedge clk);
    @(negedge clk);
    check("R10 write ack", {31'b0, wb_ack}, 32'd1);
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
  endtask

  task automatic wb_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = a;
    @(posedge clk);
    @(negedge clk);
    check("R10 read ack", {31'b0, wb_ack}, 32'd1);
    d = wb_dat_r;
    wb_cyc = 0; wb_stb = 0;
  endtask

  task automatic set_ctrl(input bit en, input bit st, input bit clr);
    wb_write(3'd0, {29'b0, clr, st, en});
    m_en = en; m_static = st;
    if (clr) model_clear();
    if (!en) begin m_good = 0; m_lock = 0; end
  endtask

  task automatic slot(input int lk, input int ch, input logic [7:0] rx, input string tag);
    bit hit;
    logic [7:0] exp;
    @(negedge clk);
    frm_stb = 1; frm_link = 3'(lk); frm_chan = 5'(ch); rx_byte = rx;
    #1;
    hit = m_en && lk == LINK && ch == CHAN;
    exp = !hit ? 8'h00 : (m_static ? m_fill : prbs_byte(g_st));
    check({tag, " tx_sel"}, {31'b0, tx_sel}, {31'b0, hit});
    check({tag, " tx_byte"}, {24'b0, tx_byte}, {24'b0, exp});
    if (hit) begin
      if (!m_static) g_st = prbs_next(g_st);
      model_rx(rx);
    end
    @(posedge clk);
    #1 frm_stb = 0;
  endtask

  task automatic check_counts(input string tag);
    logic [31:0] d;
    wb_read(3'd4, d); check({tag, " ERRS"}, d, 32'(m_err));
    wb_read(3'd5, d); check({tag, " BITS"}, d, 32'(m_bits));
    wb_read(3'd3, d); check({tag, " lock"}, d, {31'b0, m_lock});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] d;
    logic [14:0] r_st;
    logic [7:0]  rx, mask;
    void'($urandom(32'd20240611));
    g_st = 15'h7FFF; m_en = 0; m_static = 0; m_fill = 8'h00;
    model_clear();
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // Reset state (R10, R2)
    #1 check("R2 reset tx_sel", {31'b0, tx_sel}, 32'd0);
    wb_read(3'd0, d); check("R10 reset CTRL", d, 32'd0);
    wb_read(3'd1, d); check("R10 reset ROUTE", d, 32'd0);
    check_counts("R10 reset");

    // Route and enable PRBS mode
    wb_write(3'd1, (32'(CHAN) << 8) | 32'(LINK));
    wb_read(3'd1, d); check("R10 ROUTE readback", d, (32'(CHAN) << 8) | 32'(LINK));
    set_ctrl(1, 0, 0);

    // Wrong link and wrong channel (R2)
    slot(LINK - 1, CHAN, 8'hFF, "R2 other link");
    slot(LINK, CHAN + 1, 8'hFF, "R2 other chan");

    // Loopback stream with an independent phase (R1, R4)
    r_st = 15'(($urandom % 32767) + 1);
    for (int k = 0; k < 3; k++) begin
      slot(LINK, CHAN, prbs_byte(r_st), "R1 gen");
      r_st = prbs_next(r_st);
    end
    wb_read(3'd3, d); check("R4 no lock before 32 bits", d, 32'd0);
    for (int k = 0; k < 12; k++) begin
      slot(LINK, CHAN, prbs_byte(r_st), "R1 gen");
      r_st = prbs_next(r_st);
    end
    wb_read(3'd3, d); check("R4 lock after clean run", d, 32'd1);
    check_counts("R4 clean");

    // Random bit errors while locked (R5)
    for (int k = 0; k < 60; k++) begin
      mask = (($urandom % 3) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      if (($urandom % 10) == 0) mask = mask | 8'(1 << ($urandom % 8));
      slot(LINK, CHAN, prbs_byte(r_st) ^ mask, "R5 errors");
      r_st = prbs_next(r_st);
    end
    check_counts("R5 locked");

    // Clear (R9)
    set_ctrl(1, 0, 1);
    wb_read(3'd0, d); check("R9 clear bit reads zero", d, 32'd1);
    check_counts("R9 after clear");

    // Disabled: rx ignored (R7)
    set_ctrl(0, 0, 0);
    for (int k = 0; k < 5; k++) slot(LINK, CHAN, 8'($urandom), "R7 disabled");
    check_counts("R7 disabled");

    // Static mode (R3, R6)
    m_fill = 8'hA5;
    wb_write(3'd2, 32'h000000A5);
    set_ctrl(1, 1, 1);
    for (int k = 0; k < 20; k++) slot(LINK, CHAN, 8'($urandom), "R3 R6 static");
    check_counts("R6 static");

    // Back to PRBS: generator resumes where it stopped (R3)
    set_ctrl(1, 0, 0);
    slot(LINK, CHAN, 8'h00, "R3 resume");
    slot(LINK, CHAN, 8'h00, "R3 resume");

    // Saturation (R8)
    set_ctrl(1, 1, 1);
    for (int k = 0; k < 130; k++) slot(LINK, CHAN, ~m_fill, "R8 saturate");
    check_counts("R8 saturated");

    // Clear and selected slot on the same edge (R9)
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = 3'd0; wb_dat_w = 32'h7;
    frm_stb = 1; frm_link = 3'(LINK); frm_chan = 5'(CHAN); rx_byte = ~m_fill;
    #1 check("R9 concurrent tx_byte", {24'b0, tx_byte}, {24'b0, m_fill});
    @(posedge clk);
    #1 frm_stb = 0;
    @(negedge clk);
    check("R9 concurrent ack", {31'b0, wb_ack}, 32'd1);
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    model_clear();
    check_counts("R9 clear beats slot");
    slot(LINK, CHAN, ~m_fill, "R9 next slot");
    check_counts("R9 next slot counted");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule